// File: doc/BRIEF.md
# Masked-Operand Multi-Port Compute Unit

This block is a function-unit wrapper for an issue-driven pipeline. The issuer gives it an operation with a single-cycle strobe. In the same cycle it supplies a two-bit opcode, a per-port skip mask, a zero-A flag, and an immediate with its valid flag. The unit then fetches the source operands it needs from independent register-read ports. Each read port uses a request/grant handshake, and its grant may come after any number of cycles. When every operand is present, the unit evaluates a small NOP/ADD/SUB operation and offers the result on one write port with the same handshake.

The skip mask lets the issuer suppress the fetch on any subset of source ports. A skipped port raises no read request and its operand enters the datapath as zero. The zero-A flag removes the fetch on port A (zero is used), and the immediate flag removes the fetch on port B (the immediate is used). The mask takes priority over both flags. Whatever the mask, every accepted operation ends in exactly one write.

Top module: `maskop_unit`

## Requirements
- R1: After reset, `busy_o`, `wr_req_o` and every bit of `rd_req_o` are 0.
- R2: Bit i of `fetch_skip_i` belongs to source port i (bit 0 is port A, bit 1 is port B). When it is 1 at issue, `rd_req_o[i]` stays 0 for the whole operation and no operand is taken from that port.
- R3: A skipped source operand is used as zero: ADD with B skipped gives A, with A skipped gives B, with both skipped gives 0.
- R4: With `zero_a_i` set at issue, port A is not requested and zero is used as operand A.
- R5: With `imm_valid_i` set at issue, port B is not requested and `imm_data_i` is used as operand B.
- R6: A skip bit on port A overrides `zero_a_i`, and a skip bit on port B overrides `imm_valid_i`. A skipped port B uses zero, not the immediate.
- R7: Opcode encoding: 0 = NOP (result is A), 1 = ADD (A+B), 2 = SUB (A-B), 3 = reserved and behaves as NOP. Results wrap modulo 2^DATA_W. Ports beyond B are fetched but do not affect the result.
- R8: Each fetched port holds its read request from the cycle after issue until the cycle its grant is seen, and latches `rd_data_i` in that cycle. Grant delays and completion order are free per port.
- R9: `wr_req_o` rises only after every required operand is latched and while no read request is pending. It holds with stable `wr_data_o` until `wr_gnt_i`, and each operation produces exactly one write.
- R10: `busy_o` is 1 from the cycle after an accepted issue until the cycle after the write grant. An issue strobe while busy is ignored.
- R11: Opcode, skip mask, override flags and immediate are sampled only in the issue cycle; later changes on them have no effect on the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Single-cycle issue strobe |
| opcode_i | input | 2 | Operation code (R7) |
| fetch_skip_i | input | NUM_SRC | Per-port skip mask, bit i for port i |
| zero_a_i | input | 1 | Use zero for operand A |
| imm_valid_i | input | 1 | Use immediate for operand B |
| imm_data_i | input | DATA_W | Immediate value |
| rd_req_o | output | NUM_SRC | Read request per source port |
| rd_gnt_i | input | NUM_SRC | Read grant per source port |
| rd_data_i | input | NUM_SRC*DATA_W | Read data, port i at bits [i*DATA_W +: DATA_W] |
| wr_req_o | output | 1 | Write request |
| wr_gnt_i | input | 1 | Write grant |
| wr_data_o | output | DATA_W | Result data |
| busy_o | output | 1 | Operation in flight |

## Verification
The bench walks every skip-mask combination, both overrides, and the cases where the mask collides with an override. A design that let an override win over the mask, or that fetched a skipped port anyway, would either show a read request on that port or produce a result holding the stale producer value. Grants arrive after mixed delays and out of order, so a unit that wrote before its last operand arrived would emit a wrong sum. After each issue the bench scrambles the issue fields, and it pulses issue once mid-operation. A design that re-sampled its fields or accepted a second operation would show a second write or a changed result.

// File: rtl/maskop_pkg.sv
package maskop_pkg;

   typedef enum logic [1:0] {
      OPC_NOP = 2'd0,
      OPC_ADD = 2'd1,
      OPC_SUB = 2'd2,
      OPC_RSV = 2'd3
   } opc_e;

   localparam int PORT_A = 0;
   localparam int PORT_B = 1;

endpackage

// File: rtl/maskop_src_slot.sv
module maskop_src_slot #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              need_i,
   input  logic [DATA_W-1:0] preset_i,
   output logic              req_o,
   input  logic              gnt_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              ready_o,
   output logic [DATA_W-1:0] opnd_o
);

   logic              pend_q;
   logic              rdy_q;
   logic [DATA_W-1:0] val_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         rdy_q  <= 1'b0;
         val_q  <= '0;
      end else if (start_i) begin
         pend_q <= need_i;
         rdy_q  <= !need_i;
         val_q  <= need_i ? '0 : preset_i;
      end else if (pend_q && gnt_i) begin
         pend_q <= 1'b0;
         rdy_q  <= 1'b1;
         val_q  <= data_i;
      end
   end

   assign req_o   = pend_q;
   assign ready_o = rdy_q;
   assign opnd_o  = val_q;

   // R2
   no_masked_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !need_i) |=> !req_o);

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !gnt_i && !start_i) |=> req_o);

   // R8
   grant_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && gnt_i && !start_i) |=> (ready_o && !req_o && opnd_o == $past(data_i)));

endmodule

// File: rtl/maskop_alu.sv
module maskop_alu
   import maskop_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  opc_e              opc_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] y_o
);

   always_comb begin
      unique case (opc_i)
         OPC_ADD: y_o = a_i + b_i;
         OPC_SUB: y_o = a_i - b_i;
         default: y_o = a_i;
      endcase
   end

endmodule

// File: rtl/maskop_wr_stage.sv
module maskop_wr_stage #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              req_o,
   input  logic              gnt_i,
   output logic [DATA_W-1:0] data_o,
   output logic              done_o
);

   logic              req_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         data_q <= '0;
      end else if (load_i) begin
         req_q  <= 1'b1;
         data_q <= data_i;
      end else if (req_q && gnt_i) begin
         req_q  <= 1'b0;
      end
   end

   assign req_o  = req_q;
   assign data_o = data_q;
   assign done_o = req_q && gnt_i;

   // R9
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !gnt_i) |=> (req_o && $stable(data_o)));

endmodule

// File: rtl/maskop_unit.sv
module maskop_unit
   import maskop_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int NUM_SRC = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      issue_i,
   input  logic [1:0]                opcode_i,
   input  logic [NUM_SRC-1:0]        fetch_skip_i,
   input  logic                      zero_a_i,
   input  logic                      imm_valid_i,
   input  logic [DATA_W-1:0]         imm_data_i,
   output logic [NUM_SRC-1:0]        rd_req_o,
   input  logic [NUM_SRC-1:0]        rd_gnt_i,
   input  logic [NUM_SRC*DATA_W-1:0] rd_data_i,
   output logic                      wr_req_o,
   input  logic                      wr_gnt_i,
   output logic [DATA_W-1:0]         wr_data_o,
   output logic                      busy_o
);

   localparam int BUS_W = NUM_SRC * DATA_W;

   if (NUM_SRC < 2) begin : g_cfg_src
      $error("maskop_unit: NUM_SRC must be at least 2");
   end
   if (DATA_W < 1) begin : g_cfg_w
      $error("maskop_unit: DATA_W must be positive");
   end
   if (BUS_W != $bits(rd_data_i)) begin : g_cfg_bus
      $error("maskop_unit: read bus width mismatch");
   end

   logic              busy_q;
   logic              launched_q;
   opc_e              op_q;
   logic              accept;
   logic              fire;
   logic              wr_done;
   logic [NUM_SRC-1:0] ready;
   logic [DATA_W-1:0] opnd [NUM_SRC];
   logic [DATA_W-1:0] alu_y;

   assign accept = issue_i && !busy_q;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic              need;
      logic [DATA_W-1:0] preset;

      if (g == PORT_A) begin : g_port_a
         assign need   = !fetch_skip_i[g] && !zero_a_i;
         assign preset = '0;
      end else if (g == PORT_B) begin : g_port_b
         assign need   = !fetch_skip_i[g] && !imm_valid_i;
         assign preset = fetch_skip_i[g] ? '0 : imm_data_i;
      end else begin : g_port_x
         logic [DATA_W-1:0] spare_unused;
         assign need         = !fetch_skip_i[g];
         assign preset       = '0;
         assign spare_unused = opnd[g];
      end

      maskop_src_slot #(
         .DATA_W(DATA_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .start_i (accept),
         .need_i  (need),
         .preset_i(preset),
         .req_o   (rd_req_o[g]),
         .gnt_i   (rd_gnt_i[g]),
         .data_i  (rd_data_i[g*DATA_W +: DATA_W]),
         .ready_o (ready[g]),
         .opnd_o  (opnd[g])
      );
   end

   assign fire = busy_q && !launched_q && (&ready);

   maskop_alu #(
      .DATA_W(DATA_W)
   ) u_alu (
      .opc_i(op_q),
      .a_i  (opnd[PORT_A]),
      .b_i  (opnd[PORT_B]),
      .y_o  (alu_y)
   );

   maskop_wr_stage #(
      .DATA_W(DATA_W)
   ) u_wr (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(fire),
      .data_i(alu_y),
      .req_o (wr_req_o),
      .gnt_i (wr_gnt_i),
      .data_o(wr_data_o),
      .done_o(wr_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         launched_q <= 1'b0;
         op_q       <= OPC_NOP;
      end else if (accept) begin
         busy_q     <= 1'b1;
         launched_q <= 1'b0;
         op_q       <= opc_e'(opcode_i);
      end else begin
         if (fire)    launched_q <= 1'b1;
         if (wr_done) busy_q     <= 1'b0;
      end
   end

   assign busy_o = busy_q;

   // R10
   busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !busy_o) |=> busy_o);

   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !(wr_req_o && wr_gnt_i)) |=> busy_o);

   // R10
   ignore_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && issue_i) |=> (op_q == $past(op_q)));

   // R9
   no_rd_during_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o |-> (rd_req_o == '0));

   // R9
   single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && wr_gnt_i) |=> (!busy_o && !wr_req_o));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!wr_req_o && rd_req_o == '0));

endmodule

// File: tb/test_maskop_unit.sv
`timescale 1ns/1ps
module test_maskop_unit;

   localparam int DW = 16;
   localparam int NS = 3;

   typedef struct packed {
      logic [1:0]    op;
      logic [NS-1:0] skip;
      logic          za;
      logic          iv;
      logic [DW-1:0] imm;
      logic [DW-1:0] a;
      logic [DW-1:0] b;
      logic [DW-1:0] c;
      logic [1:0]    d0;
      logic [1:0]    d1;
      logic [1:0]    d2;
      logic [1:0]    dw;
      logic [DW-1:0] exp;
   } vec_t;

   // skip bit 0 = port A, bit 1 = port B, bit 2 = port C
   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 3'b000, 1'b0, 1'b0, 16'd0,   16'd9,      16'd2, 16'd0, 2'd0, 2'd0, 2'd0, 2'd0, 16'd9},
      '{2'd1, 3'b000, 1'b0, 1'b0, 16'd0,   16'd5,      16'd2, 16'd0, 2'd0, 2'd2, 2'd1, 2'd0, 16'd7},
      '{2'd2, 3'b000, 1'b0, 1'b0, 16'd0,   16'd5,      16'd2, 16'd0, 2'd2, 2'd1, 2'd0, 2'd2, 16'd3},
      '{2'd1, 3'b010, 1'b0, 1'b0, 16'd0,   16'd5,      16'd2, 16'd0, 2'd2, 2'd1, 2'd0, 2'd0, 16'd5},
      '{2'd1, 3'b001, 1'b0, 1'b0, 16'd0,   16'd5,      16'd2, 16'd0, 2'd1, 2'd2, 2'd0, 2'd1, 16'd2},
      '{2'd1, 3'b011, 1'b0, 1'b0, 16'd0,   16'd5,      16'd2, 16'd0, 2'd1, 2'd2, 2'd3, 2'd1, 16'd0},
      '{2'd0, 3'b001, 1'b0, 1'b0, 16'd0,   16'd5,      16'd2, 16'd0, 2'd0, 2'd2, 2'd1, 2'd0, 16'd0},
      '{2'd0, 3'b100, 1'b0, 1'b0, 16'd0,   16'd9,      16'd2, 16'd0, 2'd2, 2'd1, 2'd0, 2'd2, 16'd9},
      '{2'd0, 3'b111, 1'b0, 1'b0, 16'd0,   16'd9,      16'd2, 16'd0, 2'd2, 2'd1, 2'd0, 2'd2, 16'd0},
      '{2'd1, 3'b000, 1'b1, 1'b0, 16'd0,   16'd5,      16'd2, 16'd0, 2'd0, 2'd1, 2'd2, 2'd0, 16'd2},
      '{2'd1, 3'b000, 1'b0, 1'b1, 16'd100, 16'd5,      16'd2, 16'd0, 2'd3, 2'd0, 2'd1, 2'd1, 16'd105},
      '{2'd1, 3'b000, 1'b1, 1'b1, 16'd7,   16'd5,      16'd2, 16'd0, 2'd0, 2'd0, 2'd0, 2'd3, 16'd7},
      '{2'd1, 3'b010, 1'b0, 1'b1, 16'd100, 16'd5,      16'd2, 16'd0, 2'd1, 2'd0, 2'd2, 2'd0, 16'd5},
      '{2'd1, 3'b001, 1'b1, 1'b0, 16'd0,   16'd5,      16'd2, 16'd0, 2'd0, 2'd3, 2'd1, 2'd1, 16'd2},
      '{2'd2, 3'b000, 1'b0, 1'b0, 16'd0,   16'd2,      16'd5, 16'd0, 2'd1, 2'd1, 2'd1, 2'd0, 16'hFFFD},
      '{2'd3, 3'b000, 1'b0, 1'b0, 16'd0,   16'h1234,   16'd2, 16'd0, 2'd2, 2'd0, 2'd1, 2'd1, 16'h1234}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             issue_i = 1'b0;
   logic [1:0]       opcode_i = '0;
   logic [NS-1:0]    fetch_skip_i = '0;
   logic             zero_a_i = 1'b0;
   logic             imm_valid_i = 1'b0;
   logic [DW-1:0]    imm_data_i = '0;
   logic [NS-1:0]    rd_req_o;
   logic [NS-1:0]    rd_gnt_i = '0;
   logic [NS*DW-1:0] rd_data_i = '0;
   logic             wr_req_o;
   logic             wr_gnt_i = 1'b0;
   logic [DW-1:0]    wr_data_o;
   logic             busy_o;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   maskop_unit #(.DATA_W(DW), .NUM_SRC(NS)) i_maskop_unit (.*);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // Drive one operation through issue, fetch and write. When poke is set,
   // a second issue strobe is pulsed while the unit is busy.
   task automatic run_op(input vec_t v, input bit poke);
      int            cnt [NS];
      int            dly [NS];
      bit            seen [NS];
      int            wcnt;
      int            writes;
      logic [DW-1:0] got;
      bit            done;
      logic [NS-1:0] need;
      dly[0] = int'(v.d0); dly[1] = int'(v.d1); dly[2] = int'(v.d2);
      for (int i = 0; i < NS; i++) begin cnt[i] = 0; seen[i] = 1'b0; end
      wcnt = 0; writes = 0; got = '0; done = 1'b0;
      need[0] = !v.skip[0] && !v.za;
      need[1] = !v.skip[1] && !v.iv;
      need[2] = !v.skip[2];

      @(negedge clk);
      rd_data_i    = {v.c, v.b, v.a};
      opcode_i     = v.op;
      fetch_skip_i = v.skip;
      zero_a_i     = v.za;
      imm_valid_i  = v.iv;
      imm_data_i   = v.imm;
      issue_i      = 1'b1;
      @(negedge clk);
      issue_i      = 1'b0;
      // R11: scramble the issue fields after the strobe
      opcode_i     = ~v.op;
      fetch_skip_i = ~v.skip;
      zero_a_i     = ~v.za;
      imm_valid_i  = ~v.iv;
      imm_data_i   = ~v.imm;
      chk(busy_o == 1'b1, "R10 busy after issue", 32'(busy_o), 32'd1);

      for (int cyc = 0; cyc < 40 && !done; cyc++) begin
         if (cyc > 0) @(negedge clk);
         issue_i = poke && (cyc == 1);
         if (wr_gnt_i) begin
            writes++;
            wr_gnt_i = 1'b0;
            done = 1'b1;
         end else begin
            if (wr_req_o && (rd_req_o != '0))
               chk(1'b0, "R9 write while read pending", 32'(rd_req_o), 32'd0);
            for (int i = 0; i < NS; i++) begin
               rd_gnt_i[i] = 1'b0;
               if (rd_req_o[i]) begin
                  seen[i] = 1'b1;
                  if (cnt[i] >= dly[i]) rd_gnt_i[i] = 1'b1;
                  else cnt[i]++;
               end
            end
            if (wr_req_o) begin
               if (wcnt >= int'(v.dw)) begin
                  wr_gnt_i = 1'b1;
                  got = wr_data_o;
               end else wcnt++;
            end
         end
      end
      issue_i  = 1'b0;
      rd_gnt_i = '0;
      chk(done, "R9 write completed", 32'(done), 32'd1);
      chk(got == v.exp, "R3/R4/R5/R6/R7 result", 32'(got), 32'(v.exp));
      chk({seen[2], seen[1], seen[0]} == need, "R2/R4/R5/R6 fetched ports",
          32'({seen[2], seen[1], seen[0]}), 32'(need));
      chk(busy_o == 1'b0, "R10 idle after write grant", 32'(busy_o), 32'd1 - 32'd1);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (wr_req_o) writes++;
         if (rd_req_o != '0) writes++;
      end
      chk(writes == 1, "R9 one write per operation", 32'(writes), 32'd1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin : main
      vec_t v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(busy_o == 1'b0, "R1 busy in reset", 32'(busy_o), 32'd0);
      chk(rd_req_o == '0, "R1 read requests in reset", 32'(rd_req_o), 32'd0);
      chk(wr_req_o == 1'b0, "R1 write request in reset", 32'(wr_req_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 1'b0 && rd_req_o == '0, "R1 idle after reset",
          32'({busy_o, rd_req_o}), 32'd0);

      // table walk
      for (int n = 0; n < NV; n++) begin
         run_op(VECS[n], 1'b0);
      end

      // R10: issue pulse while busy is ignored (ADD 5+2, grants slow)
      v = '{2'd1, 3'b000, 1'b0, 1'b0, 16'd0, 16'd5, 16'd2, 16'd0,
            2'd3, 2'd3, 2'd3, 2'd2, 16'd7};
      run_op(v, 1'b1);

      // R8: all grants at once on the first request cycle, ADD 40000+30000 wraps
      v = '{2'd1, 3'b000, 1'b0, 1'b0, 16'd0, 16'd40000, 16'd30000, 16'd1,
            2'd0, 2'd0, 2'd0, 2'd0, 16'd4464};
      run_op(v, 1'b0);

      // R8: request held while grant withheld
      @(negedge clk);
      rd_data_i    = {16'd0, 16'd3, 16'd4};
      opcode_i     = 2'd1;
      fetch_skip_i = 3'b000;
      zero_a_i     = 1'b0;
      imm_valid_i  = 1'b0;
      issue_i      = 1'b1;
      @(negedge clk);
      issue_i = 1'b0;
      repeat (5) @(negedge clk);
      chk(rd_req_o == 3'b111, "R8 requests held without grant", 32'(rd_req_o), 32'd7);
      chk(wr_req_o == 1'b0, "R9 no write before operands", 32'(wr_req_o), 32'd0);
      rd_gnt_i = 3'b111;
      @(negedge clk);
      rd_gnt_i = '0;
      chk(rd_req_o == 3'b000, "R8 requests drop after grant", 32'(rd_req_o), 32'd0);
      @(negedge clk);
      chk(wr_req_o && wr_data_o == 16'd7, "R9 write offered with result",
          32'(wr_data_o), 32'd7);
      repeat (3) @(negedge clk);
      chk(wr_req_o && wr_data_o == 16'd7, "R9 write held until grant",
          32'(wr_data_o), 32'd7);
      wr_gnt_i = 1'b1;
      @(negedge clk);
      wr_gnt_i = 1'b0;
      chk(!busy_o && !wr_req_o, "R10 release after write grant",
          32'({busy_o, wr_req_o}), 32'd0);

      summary();
   end

endmodule